// File: doc/BRIEF.md
# Averaging Scan Sequencer for a Multichannel Converter

This block sits on the device side of a successive-approximation converter. Given a clock-mode code, an averaging switch and count code, and the highest channel to visit, it decides how many acquisitions to request and in what order. It also decides whether each acquisition needs its own trigger. It sums the samples of each channel and divides the sum by the sample count with a right shift. It pushes one averaged word per channel into a small result queue and pulls an active-low done line low once the whole scan has landed in that queue.

The analog side is a stub: the sequencer raises `acq_start` for one cycle with a channel number, and the stub later answers with a one-cycle `conv_done` carrying `conv_data`. The configuration inputs are captured when a scan starts, so they may change while a scan runs. A controller reads results through a first-word-fall-through port (`rd_valid`, `rd_data`, `rd_en`). `trig` stands for whatever start event the serial front end decodes: a strobe pin or the chip-select release.

Top module: `avg_scan_seq`

## Requirements
- R1: Samples per channel: with `avg_en`=0 each channel takes 1 sample. With `avg_en`=1, `avg_code` 00 selects 4, 01 selects 8, 10 selects 16 and 11 selects 32.
- R2: Each stored result is the unsigned sum of that channel's samples shifted right by log2 of the sample count, `DW` bits wide.
- R3: In clock modes 00, 01 and 10 a scan converts channels 0 through `last_ch` in rising order. The queue gets exactly one result per channel, and reads return them in channel order.
- R4: In clock modes 00 and 10 one `trig` accepted while idle runs every acquisition of the scan back to back, with no further trigger.
- R5: In clock mode 01 the first `trig` starts the first acquisition, and each later acquisition is requested only after a new `trig`. With a single channel and N samples, N triggers yield one result.
- R6: `scan_done_n` rises when a scan starts. It falls in the same cycle that the last result of the scan becomes readable, and never earlier.
- R7: In clock mode 11 a trigger converts channel `last_ch` once with averaging ignored, stores that one sample, and `scan_done_n` stays high.
- R8: A one-cycle `fifo_clr` empties the queue (`rd_valid`=0), drives `scan_done_n` high and clears `overrun`.
- R9: A `trig` that arrives while an acquisition is pending or in progress does not change the scan. It sets `overrun`, which stays set until `fifo_clr`.
- R10: After reset `scan_done_n`=1, `overrun`=0, `busy`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_mode | input | 2 | Clock-mode code (00, 01, 10, 11) |
| avg_en | input | 1 | Averaging enable |
| avg_code | input | 2 | Averaging count code |
| last_ch | input | CH_W | Highest channel of the scan (the only channel in mode 11) |
| trig | input | 1 | One-cycle start or acquisition trigger |
| fifo_clr | input | 1 | One-cycle queue clear |
| conv_done | input | 1 | One-cycle conversion complete pulse from the stub |
| conv_data | input | DW | Sample value valid with `conv_done` |
| rd_en | input | 1 | Pop the head of the result queue |
| acq_start | output | 1 | One-cycle acquisition request |
| acq_ch | output | CH_W | Channel of the requested acquisition |
| scan_done_n | output | 1 | Active-low end of scan |
| overrun | output | 1 | Sticky: trigger arrived during an acquisition |
| busy | output | 1 | Scan in progress |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | DW | Head of the queue |

## Verification
The bench sweeps every averaging setting against every scan length in both self-timed modes and compares each stored word with an average computed from the samples the stub handed out. An off-by-one sample count or a wrong shift would show as a wrong value, and a channel skipped or repeated would show as a wrong order or count. In the per-trigger mode it holds off each trigger and checks that no request leaks out. A sequencer that free-runs there would issue acquisitions early. The bench also checks that the done line is still high while conversions remain, so a line that falls on the first channel's result is caught. Further cases cover a mid-scan trigger that must not disturb the results, the single-shot external mode whose done line must stay high, and a clear issued over unread data.

// File: rtl/adc_seq_pkg.sv
// Shared types for the averaging scan sequencer.
// Assumes: averaging codes map to 4/8/16/32 samples, so shifts stay below 6.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        CM_SCAN_STROBE = 2'b00,
        CM_PER_ACQ     = 2'b01,
        CM_SCAN_SELECT = 2'b10,
        CM_EXTERNAL    = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_ACQ,
        SQ_WAIT
    } seq_state_e;

    // log2 of the sample count for one channel
    function automatic logic [2:0] avg_shift(input logic en, input logic [1:0] code);
        return en ? (3'd2 + {1'b0, code}) : 3'd0;
    endfunction

endpackage

// File: rtl/seq_ctrl.sv
// Scan controller: captures the configuration at start, walks channels
// and samples, requests acquisitions, and drives done and overrun.
// Assumes conv_done only arrives after an acquisition request.
module seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      clk_mode,
    input  logic            avg_en,
    input  logic [1:0]      avg_code,
    input  logic [CH_W-1:0] last_ch,
    input  logic            trig,
    input  logic            fifo_clr,
    input  logic            conv_done,
    output logic            acq_start,
    output logic [CH_W-1:0] acq_ch,
    output logic            sample_add,
    output logic            sample_last,
    output logic [2:0]      shift_q,
    output logic            scan_done_n,
    output logic            overrun,
    output logic            busy
);

    seq_state_e      state;
    clk_mode_e       mode_q;
    logic [CH_W-1:0] ch_q;
    logic [CH_W-1:0] last_q;
    logic [4:0]      cnt_q;
    logic [5:0]      n_smp;
    logic            last_smp;
    logic            start;
    logic            scan_end;

    assign n_smp       = 6'd1 << shift_q;
    assign last_smp    = ({1'b0, cnt_q} == (n_smp - 6'd1));
    assign start       = (state == SQ_IDLE) && trig;
    assign sample_add  = (state == SQ_ACQ) && conv_done;
    assign sample_last = sample_add && last_smp;
    assign scan_end    = sample_last && (ch_q == last_q);
    assign acq_start   = (state == SQ_REQ);
    assign acq_ch      = ch_q;
    assign busy        = (state != SQ_IDLE);

    // State sequencing between idle, request, acquisition and trigger wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            case (state)
                SQ_IDLE: if (trig) state <= SQ_REQ;
                SQ_REQ:  state <= SQ_ACQ;
                SQ_ACQ: begin
                    if (sample_add) begin
                        if (scan_end)                 state <= SQ_IDLE;
                        else if (mode_q == CM_PER_ACQ) state <= SQ_WAIT;
                        else                          state <= SQ_REQ;
                    end
                end
                SQ_WAIT: if (trig) state <= SQ_REQ;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Configuration capture and channel / sample counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= CM_SCAN_STROBE;
            ch_q    <= '0;
            last_q  <= '0;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (start) begin
            mode_q <= clk_mode_e'(clk_mode);
            last_q <= last_ch;
            cnt_q  <= '0;
            if (clk_mode_e'(clk_mode) == CM_EXTERNAL) begin
                ch_q    <= last_ch;
                shift_q <= '0;
            end else begin
                ch_q    <= '0;
                shift_q <= avg_shift(avg_en, avg_code);
            end
        end else if (sample_add) begin
            if (last_smp) begin
                cnt_q <= '0;
                if (!scan_end) ch_q <= ch_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 5'd1;
            end
        end
    end

    // Active-low done line: clear wins, start raises, scan end lowers
    always_ff @(posedge clk) begin
        if (!rst_n)                                   scan_done_n <= 1'b1;
        else if (fifo_clr)                            scan_done_n <= 1'b1;
        else if (start)                               scan_done_n <= 1'b1;
        else if (scan_end && mode_q != CM_EXTERNAL)   scan_done_n <= 1'b0;
    end

    // Sticky overrun on a trigger during a pending or running acquisition
    always_ff @(posedge clk) begin
        if (!rst_n)                                           overrun <= 1'b0;
        else if (fifo_clr)                                    overrun <= 1'b0;
        else if (trig && (state == SQ_REQ || state == SQ_ACQ)) overrun <= 1'b1;
    end

    p_ext_keeps_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == CM_EXTERNAL) |=> scan_done_n);

    p_wait_blocks_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT && !trig) |=> !acq_start);

    p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(trig) && $past(busy)));

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_done_n) |-> ($past(conv_done) && $past(busy)));

endmodule

// File: rtl/avg_accum.sv
// Per-channel accumulator: adds each accepted sample, and on the last
// sample of a channel emits (sum >> shift) and clears itself.
// Assumes at most 32 samples per channel, hence 5 guard bits.
module avg_accum #(
    parameter int DW    = 12,
    localparam int ACC_W = DW + 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add,
    input  logic          is_last,
    input  logic [2:0]    shift,
    input  logic [DW-1:0] din,
    output logic          res_valid,
    output logic [DW-1:0] res_data
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] avg;

    assign sum       = acc_q + ACC_W'(din);
    assign avg       = sum >> shift;
    assign res_valid = add && is_last;
    assign res_data  = avg[DW-1:0];

    // Running sum of the current channel
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (add)    acc_q <= is_last ? '0 : sum;
    end

    p_avg_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (avg < (ACC_W'(1) << DW)));

endmodule

// File: rtl/result_fifo.sv
// Result queue with first-word-fall-through read. A push into a full
// queue is dropped; a pop of an empty queue is ignored; clear wins.
// Assumes DEPTH is a power of two.
module result_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   count;
    logic          do_push;
    logic          do_pop;

    assign do_push  = push && (count != (AW+1)'(DEPTH));
    assign do_pop   = pop && (count != '0);
    assign rd_valid = (count != '0);
    assign rd_data  = mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));

    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rd_valid);

endmodule

// File: rtl/avg_scan_seq.sv
// Top of the averaging scan sequencer: controller, accumulator and
// result queue. The analog conversion is an external stub answering
// acq_start with conv_done/conv_data.
module avg_scan_seq #(
    parameter int DW    = 12,
    parameter int CH_W  = 2,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      clk_mode,
    input  logic            avg_en,
    input  logic [1:0]      avg_code,
    input  logic [CH_W-1:0] last_ch,
    input  logic            trig,
    input  logic            fifo_clr,
    input  logic            conv_done,
    input  logic [DW-1:0]   conv_data,
    input  logic            rd_en,
    output logic            acq_start,
    output logic [CH_W-1:0] acq_ch,
    output logic            scan_done_n,
    output logic            overrun,
    output logic            busy,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data
);

    logic          sample_add;
    logic          sample_last;
    logic [2:0]    shift_q;
    logic          res_valid;
    logic [DW-1:0] res_data;

    seq_ctrl #(.CH_W(CH_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_mode    (clk_mode),
        .avg_en      (avg_en),
        .avg_code    (avg_code),
        .last_ch     (last_ch),
        .trig        (trig),
        .fifo_clr    (fifo_clr),
        .conv_done   (conv_done),
        .acq_start   (acq_start),
        .acq_ch      (acq_ch),
        .sample_add  (sample_add),
        .sample_last (sample_last),
        .shift_q     (shift_q),
        .scan_done_n (scan_done_n),
        .overrun     (overrun),
        .busy        (busy)
    );

    avg_accum #(.DW(DW)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .add       (sample_add),
        .is_last   (sample_last),
        .shift     (shift_q),
        .din       (conv_data),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    result_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (res_valid),
        .push_data (res_data),
        .pop       (rd_en),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    p_done_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_done_n) |-> rd_valid);

endmodule

// File: tb/avg_scan_seq_tb.sv
module avg_scan_seq_tb;

    localparam int DW   = 12;
    localparam int CH_W = 2;
    localparam int LAT  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      clk_mode = 2'b00;
    logic            avg_en = 1'b0;
    logic [1:0]      avg_code = 2'b00;
    logic [CH_W-1:0] last_ch = '0;
    logic            trig = 1'b0;
    logic            fifo_clr = 1'b0;
    logic            conv_done = 1'b0;
    logic [DW-1:0]   conv_data = '0;
    logic            rd_en = 1'b0;
    logic            acq_start;
    logic [CH_W-1:0] acq_ch;
    logic            scan_done_n;
    logic            overrun;
    logic            busy;
    logic            rd_valid;
    logic [DW-1:0]   rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int n_acq = 0;
    int n_done = 0;
    int sidx [4];
    int order_err = 0;
    int exp_ch = 0;
    int exp_cnt = 0;
    int exp_n = 1;

    always #5 clk = ~clk;

    avg_scan_seq #(.DW(DW), .CH_W(CH_W), .DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .avg_en(avg_en),
        .avg_code(avg_code), .last_ch(last_ch), .trig(trig), .fifo_clr(fifo_clr),
        .conv_done(conv_done), .conv_data(conv_data), .rd_en(rd_en),
        .acq_start(acq_start), .acq_ch(acq_ch), .scan_done_n(scan_done_n),
        .overrun(overrun), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic int smp(input int ch, input int idx);
        return (ch * 613 + idx * 97 + 5 * idx * idx + 300) % 4096;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Conversion stub: answers each request LAT cycles later and tracks order (R3)
    initial begin
        int timer;
        int lch;
        timer = 0;
        lch = 0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (timer > 0) begin
                timer--;
                if (timer == 0) begin
                    conv_data = DW'(smp(lch, sidx[lch]));
                    sidx[lch]++;
                    conv_done = 1'b1;
                    n_done++;
                end
            end
            if (acq_start) begin
                if (int'(acq_ch) != exp_ch) order_err++;
                exp_cnt++;
                if (exp_cnt == exp_n) begin
                    exp_cnt = 0;
                    exp_ch++;
                end
                timer = LAT;
                lch = int'(acq_ch);
                n_acq++;
            end
        end
    end

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic pulse_clr();
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic prep(input int m, input int en, input int code, input int lc);
        for (int c = 0; c < 4; c++) sidx[c] = 0;
        n_acq = 0;
        n_done = 0;
        order_err = 0;
        exp_cnt = 0;
        exp_ch = (m == 3) ? lc : 0;
        exp_n = (m == 3) ? 1 : (en != 0 ? (4 << code) : 1);
        clk_mode = 2'(m);
        avg_en = en[0];
        avg_code = 2'(code);
        last_ch = CH_W'(lc);
    endtask

    task automatic drain(input int m, input int lc, input int n, input int k);
        int first;
        int nres;
        first = (m == 3) ? lc : 0;
        nres  = (m == 3) ? 1 : lc + 1;
        for (int c = 0; c < nres; c++) begin
            int sum;
            int exp;
            sum = 0;
            for (int i = 0; i < n; i++) sum += smp(first + c, i);
            exp = sum >> k;
            chk(rd_valid && int'(rd_data) == exp, "R1 R2 R3 result", int'(rd_data), exp);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(!rd_valid, "R3 one result per channel", int'(rd_valid), 0);
        chk(order_err == 0, "R3 channel order", order_err, 0);
    endtask

    // One scan in a self-timed mode (00, 10) or the external mode (11)
    task automatic run_auto(input int m, input int en, input int code, input int lc);
        int n;
        int k;
        int early;
        int guard;
        prep(m, en, code, lc);
        n = exp_n;
        k = (m == 3 || en == 0) ? 0 : code + 2;
        early = 0;
        guard = 0;
        pulse_trig();
        while (busy && guard < 2000) begin
            if (!scan_done_n) early++;
            @(negedge clk);
            guard++;
        end
        chk(guard < 2000, "R4 scan completes without extra trigger", guard, 0);
        chk(early == 0, "R6 done stays high during scan", early, 0);
        if (m == 3) begin
            chk(scan_done_n == 1'b1, "R7 done untouched", int'(scan_done_n), 1);
            chk(n_acq == 1, "R7 single acquisition", n_acq, 1);
        end else begin
            chk(scan_done_n == 1'b0, "R6 done low at end", int'(scan_done_n), 0);
            chk(n_done == n * (lc + 1), "R6 all conversions before done", n_done, n * (lc + 1));
        end
        drain(m, lc, n, k);
        pulse_clr();
        chk(scan_done_n == 1'b1, "R8 clear raises done", int'(scan_done_n), 1);
    endtask

    // One scan in the per-trigger mode 01
    task automatic run_pertrig(input int en, input int code, input int lc);
        int n;
        int k;
        int total;
        int guard;
        prep(1, en, code, lc);
        n = exp_n;
        k = (en == 0) ? 0 : code + 2;
        total = n * (lc + 1);
        pulse_trig();
        for (int i = 0; i < total; i++) begin
            guard = 0;
            while (n_done < i + 1 && guard < 100) begin
                @(negedge clk);
                guard++;
            end
            if (i < total - 1) begin
                repeat (6) @(negedge clk);
                chk(n_acq == i + 1, "R5 no request without trigger", n_acq, i + 1);
                chk(busy && scan_done_n, "R5 waiting mid-scan", int'(scan_done_n), 1);
                pulse_trig();
            end
        end
        repeat (3) @(negedge clk);
        chk(!busy && scan_done_n == 1'b0, "R5 R6 done after last trigger", int'(scan_done_n), 0);
        chk(!overrun, "R9 no overrun for paced triggers", int'(overrun), 0);
        drain(1, lc, n, k);
        pulse_clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scan_done_n == 1'b1, "R10 reset done", int'(scan_done_n), 1);
        chk(!overrun && !busy, "R10 reset flags", int'(overrun), 0);
        chk(!rd_valid, "R10 reset queue empty", int'(rd_valid), 0);

        // R1 R2 R3 R4: sweep both self-timed modes over all settings
        for (int m = 0; m < 3; m += 2)
            for (int en = 0; en < 2; en++)
                for (int code = 0; code < 4; code++)
                    for (int lc = 0; lc < 4; lc++)
                        run_auto(m, en, code, lc);

        // R5: per-trigger mode
        run_pertrig(1, 0, 0);
        run_pertrig(1, 1, 3);
        run_pertrig(0, 0, 2);
        run_pertrig(1, 3, 1);

        // R7: external mode ignores averaging and scanning
        run_auto(3, 1, 3, 2);
        run_auto(3, 0, 0, 0);

        // R9: trigger during an acquisition is ignored and flagged
        prep(0, 1, 0, 1);
        pulse_trig();
        repeat (2) @(negedge clk);
        pulse_trig();
        chk(overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
        begin
            int guard;
            guard = 0;
            while (busy && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
        end
        chk(n_acq == 8, "R9 scan unchanged by extra trigger", n_acq, 8);
        chk(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);
        drain(0, 1, 4, 2);
        pulse_clr();
        chk(overrun == 1'b0, "R8 clear drops overrun", int'(overrun), 0);

        // R8: clear over unread results
        prep(2, 1, 1, 3);
        pulse_trig();
        begin
            int guard;
            guard = 0;
            while (busy && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
        end
        chk(rd_valid && !scan_done_n, "R8 data present before clear", int'(rd_valid), 1);
        pulse_clr();
        chk(!rd_valid, "R8 queue emptied", int'(rd_valid), 0);
        chk(scan_done_n == 1'b1, "R8 done high after clear", int'(scan_done_n), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule